// File: doc/BRIEF.md
# SIMT Divergence Mask Sequencer

This block steers a warp of parallel lanes through a conditional branch whose condition may come out differently in different lanes. At branch start it takes the warp's lane mask and a per-lane condition vector, then presents an execution mask for the taken path. When that path ends, it presents the mask for the fall-through path. After the second path it hands back the mask that was in force before the branch, so the lanes rejoin. A path whose mask has no lanes in it is not presented at all.

A branch may open while a path is already running. In that case the running path's mask becomes the base mask of the inner branch. The context of each open branch is held on a small reconvergence stack. A branch that arrives with the stack full is refused, and a sticky error flag records it. When no branch is open, the execution mask follows the warp mask input, one cycle late. The block does not execute instructions and does not write results. It only produces the lane enables that the execution stages obey.

Top module: `simt_diverge_seq`

## Requirements
- R1: Under synchronous reset, and on the first cycle after it, exec_mask_o is 0, phase_o is 2'd0, busy_o is 0 and overflow_o is 0, whatever the other inputs are doing.
- R2: While no branch is open, exec_mask_o equals the value active_mask_i had at the previous clock edge, and phase_o is 2'd0.
- R3: Take the base mask B (active_mask_i when no branch is open, otherwise the current exec_mask_o) and the condition vector P. An accepted branch_start_i with B&P nonzero gives exec_mask_o = B&P and phase_o = 2'd1 (taken) on the next cycle.
- R4: A path_end_i during the taken path gives exec_mask_o = B&~P and phase_o = 2'd2 (fall-through) on the next cycle, provided that mask is nonzero.
- R5: An empty path is skipped. If B&P is zero, the branch opens straight into phase 2'd2 with B&~P. If B&~P is zero, path_end_i in the taken path reconverges at once.
- R6: A path_end_i that closes the last path of a branch restores exec_mask_o to that branch's B. phase_o returns to the enclosing branch's phase, or to 2'd0 when no branch remains open.
- R7: Branches nest up to DEPTH levels. An inner branch uses the current exec_mask_o as its B and, after it reconverges, the outer path resumes with its own mask and phase.
- R8: A branch_start_i while DEPTH branches are open is refused. The refused branch leaves exec_mask_o, phase_o and busy_o unchanged and sets overflow_o, which stays 1 until reset.
- R9: busy_o is 1 from the cycle after an accepted branch until the cycle after the outermost branch reconverges, and 0 otherwise.
- R10: When branch_start_i and path_end_i are both high in the same cycle, path_end_i is ignored and only the branch is acted on.
- R11: path_end_i while no branch is open has no effect.
- R12: A branch whose B is all zeros opens nothing. busy_o stays 0 and phase_o stays 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_mask_i | input | LANES | Warp lane mask; used as the base when no branch is open |
| branch_start_i | input | 1 | Opens a branch for one cycle |
| branch_pred_i | input | LANES | Per-lane branch condition, sampled with branch_start_i |
| path_end_i | input | 1 | Marks the end of the path that is currently running |
| exec_mask_o | output | LANES | Registered lane enables for the current path |
| phase_o | output | 2 | 0 no branch, 1 taken path, 2 fall-through path |
| busy_o | output | 1 | At least one branch is open |
| overflow_o | output | 1 | Sticky: a branch was refused because the stack was full |

## Verification
A branch start and a path end can arrive in the same cycle, and a branch start can also hit a full stack. The bench raises both strobes together while a path is running, and again on the refused branch at full depth. It then checks on the next cycle that only the branch took effect: the inner taken mask appears and the stack depth grows. For the refused branch, the mask and phase must stay frozen while the error flag rises. Every base and condition pair of a four-lane configuration is swept through a complete branch, and each output is compared with a reference stack model kept in the bench.

// File: rtl/simt_dms_pkg.sv
package simt_dms_pkg;
  typedef enum logic [1:0] {
    PH_UNIFORM = 2'd0,
    PH_TAKEN   = 2'd1,
    PH_ELSE    = 2'd2
  } path_phase_e;
endpackage

// File: rtl/dms_split.sv
module dms_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] base_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] taken_o,
  output logic [LANES-1:0] else_o,
  output logic             taken_any_o,
  output logic             else_any_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign taken_o[g] = base_i[g] & pred_i[g];
    assign else_o[g]  = base_i[g] & ~pred_i[g];
  end

  assign taken_any_o = |taken_o;
  assign else_any_o  = |else_o;
endmodule

// File: rtl/dms_stack.sv
module dms_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             mark_else_i,
  input  logic [LANES-1:0] push_restore_i,
  input  logic [LANES-1:0] push_alt_i,
  input  logic             push_in_else_i,
  output logic [PW-1:0]    sp_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LANES-1:0] top_restore_o,
  output logic [LANES-1:0] top_alt_o,
  output logic             top_in_else_o,
  output logic             under_in_else_o
);
  logic [LANES-1:0] restore_mem [DEPTH];
  logic [LANES-1:0] alt_mem     [DEPTH];
  logic [DEPTH-1:0] in_else_q;
  logic [PW-1:0]    sp_q;
  logic [IW-1:0]    wr_idx, top_idx, under_idx;

  assign empty_o   = (sp_q == '0);
  assign full_o    = (sp_q == PW'(DEPTH));
  assign wr_idx    = IW'(sp_q);
  assign top_idx   = empty_o ? '0 : IW'(sp_q - PW'(1));
  assign under_idx = (sp_q >= PW'(2)) ? IW'(sp_q - PW'(2)) : '0;

  // Mask storage: write-only-on-push, no reset, so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_i) begin
      restore_mem[wr_idx] <= push_restore_i;
      alt_mem[wr_idx]     <= push_alt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= '0;
      in_else_q <= '0;
    end else begin
      if (push_i) begin
        sp_q              <= sp_q + PW'(1);
        in_else_q[wr_idx] <= push_in_else_i;
      end else if (pop_i) begin
        sp_q <= sp_q - PW'(1);
      end
      if (mark_else_i) in_else_q[top_idx] <= 1'b1;
    end
  end

  assign sp_o            = sp_q;
  assign top_restore_o   = restore_mem[top_idx];
  assign top_alt_o       = alt_mem[top_idx];
  assign top_in_else_o   = in_else_q[top_idx];
  assign under_in_else_o = in_else_q[under_idx];

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full_o));
  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
    !((pop_i || mark_else_i) && empty_o));
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
    sp_q <= PW'(DEPTH));
  assert_single_op_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({push_i, pop_i, mark_else_i}) <= 1);
endmodule

// File: rtl/simt_diverge_seq.sv
module simt_diverge_seq #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] active_mask_i,
  input  logic             branch_start_i,
  input  logic [LANES-1:0] branch_pred_i,
  input  logic             path_end_i,
  output logic [LANES-1:0] exec_mask_o,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic             overflow_o
);
  import simt_dms_pkg::*;
  localparam int PW = $clog2(DEPTH + 1);

  logic [LANES-1:0] exec_q, exec_d, base_m, taken_m, else_m;
  logic [LANES-1:0] top_restore, top_alt;
  logic             taken_any, else_any, top_in_else, under_in_else;
  logic             empty, full, busy_q, busy_d, err_q;
  logic             accept_br, push, pe_live, to_else, pop;
  logic [PW-1:0]    sp;
  path_phase_e      phase_q, phase_d;

  // The base is the warp mask outside any branch, else the running path's mask.
  assign base_m = empty ? active_mask_i : exec_q;

  dms_split #(.LANES(LANES)) u_split (
    .base_i(base_m), .pred_i(branch_pred_i),
    .taken_o(taken_m), .else_o(else_m),
    .taken_any_o(taken_any), .else_any_o(else_any)
  );

  // Branch start wins over path end in the same cycle.
  assign accept_br = branch_start_i && !full;
  assign push      = accept_br && (taken_any || else_any);
  assign pe_live   = path_end_i && !branch_start_i && !empty;
  assign to_else   = pe_live && !top_in_else && (top_alt != '0);
  assign pop       = pe_live && !to_else;

  dms_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push_i(push), .pop_i(pop), .mark_else_i(to_else),
    .push_restore_i(base_m), .push_alt_i(else_m), .push_in_else_i(!taken_any),
    .sp_o(sp), .empty_o(empty), .full_o(full),
    .top_restore_o(top_restore), .top_alt_o(top_alt),
    .top_in_else_o(top_in_else), .under_in_else_o(under_in_else)
  );

  always_comb begin
    exec_d  = exec_q;
    phase_d = phase_q;
    busy_d  = busy_q;
    if (push) begin
      exec_d  = taken_any ? taken_m : else_m;
      phase_d = taken_any ? PH_TAKEN : PH_ELSE;
      busy_d  = 1'b1;
    end else if (to_else) begin
      exec_d  = top_alt;
      phase_d = PH_ELSE;
    end else if (pop) begin
      exec_d = top_restore;
      if (sp == PW'(1)) begin
        phase_d = PH_UNIFORM;
        busy_d  = 1'b0;
      end else begin
        phase_d = under_in_else ? PH_ELSE : PH_TAKEN;
      end
    end else if (empty) begin
      exec_d = active_mask_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q  <= '0;
      phase_q <= PH_UNIFORM;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      exec_q  <= exec_d;
      phase_q <= phase_d;
      busy_q  <= busy_d;
      if (branch_start_i && full) err_q <= 1'b1;
    end
  end

  assign exec_mask_o = exec_q;
  assign phase_o     = phase_q;
  assign busy_o      = busy_q;
  assign overflow_o  = err_q;

  assert_busy_depth_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q == !empty);
  assert_idle_uniform_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (phase_q == PH_UNIFORM));
  assert_no_empty_path_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (exec_q != '0));
  assert_mask_within_base_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((exec_q & ~top_restore) == '0));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  assert_refused_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (branch_start_i && full) |=> ($stable(exec_q) && $stable(phase_q)));
endmodule

// File: tb/sim_simt_diverge_seq.sv
`timescale 1ns/1ps
module sim_simt_diverge_seq;
  localparam int L = 4;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [L-1:0] act = '0, pred = '0;
  logic         bs = 1'b0, pe = 1'b0;
  logic [L-1:0] exec_mask_o;
  logic [1:0]   phase_o;
  logic         busy_o, overflow_o;

  always #2 clk = ~clk;

  simt_diverge_seq #(.LANES(L), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .active_mask_i(act), .branch_start_i(bs),
    .branch_pred_i(pred), .path_end_i(pe), .exec_mask_o(exec_mask_o),
    .phase_o(phase_o), .busy_o(busy_o), .overflow_o(overflow_o)
  );

  int n_cmp = 0, n_bad = 0;

  // Reference stack model built from the requirements.
  logic [L-1:0] m_exec = '0;
  logic [1:0]   m_phase = 2'd0;
  int           m_sp = 0;
  logic         m_err = 1'b0;
  logic [L-1:0] m_rest [D];
  logic [L-1:0] m_alt  [D];
  bit           m_inel [D];
  string        m_tag = "R1";

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic verify();
    check(m_tag, "exec_mask", 32'(exec_mask_o), 32'(m_exec));
    check(m_tag, "phase", 32'(phase_o), 32'(m_phase));
    check("R9", "busy", 32'(busy_o), 32'(m_sp != 0));
    check(m_err ? "R8" : m_tag, "overflow", 32'(overflow_o), 32'(m_err));
  endtask

  task automatic model_edge();
    logic [L-1:0] b, t, f;
    b = (m_sp == 0) ? act : m_exec;
    t = b & pred;
    f = b & ~pred;
    if (bs) begin
      if (m_sp == D) begin
        m_err = 1'b1; m_tag = "R8";
      end else if ((t | f) == '0) begin
        m_exec = act; m_tag = "R12";
      end else begin
        m_rest[m_sp] = b; m_alt[m_sp] = f; m_inel[m_sp] = (t == '0);
        m_tag = pe ? "R10" : (m_sp > 0) ? "R7" : (t == '0) ? "R5" : "R3";
        m_sp++;
        m_exec  = (t != '0) ? t : f;
        m_phase = (t != '0) ? 2'd1 : 2'd2;
      end
    end else if (pe && m_sp > 0) begin
      if (!m_inel[m_sp-1] && m_alt[m_sp-1] != '0) begin
        m_inel[m_sp-1] = 1'b1; m_exec = m_alt[m_sp-1]; m_phase = 2'd2; m_tag = "R4";
      end else begin
        m_tag  = m_inel[m_sp-1] ? "R6" : "R5";
        m_exec = m_rest[m_sp-1];
        m_sp--;
        m_phase = (m_sp == 0) ? 2'd0 : (m_inel[m_sp-1] ? 2'd2 : 2'd1);
      end
    end else if (m_sp == 0) begin
      m_exec = act;
      m_tag  = pe ? "R11" : "R2";
    end else begin
      m_tag = "R7";
    end
  endtask

  task automatic step(logic b_s, logic [L-1:0] p, logic p_e, logic [L-1:0] a);
    bs = b_s; pred = p; pe = p_e; act = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bs = 1'b0; pe = 1'b0;
    verify();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds everything cleared even with live inputs
    act = 4'hF; bs = 1'b1; pred = 4'h5; pe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_tag = "R1";
    verify();
    bs = 1'b0; pe = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "exec_after_reset", 32'(exec_mask_o), 32'(4'hF));
    m_exec = 4'hF;

    // Exhaustive single-level sweep over base and condition (R2..R6, R12)
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 16; p++) begin
        step(1'b0, '0, 1'b0, L'(b));
        step(1'b1, L'(p), 1'b0, L'(b));
        for (int k = 0; k < 3 && m_sp != 0; k++)
          step(1'b0, '0, 1'b1, ~L'(b));
        step(1'b0, '0, 1'b0, L'(b ^ p));
      end
    end

    // R11: path end with nothing open
    step(1'b0, '0, 1'b1, 4'h6);
    step(1'b0, '0, 1'b1, 4'h9);

    // R7/R10: nesting, with a simultaneous path end on the inner start
    step(1'b0, '0, 1'b0, 4'hF);
    step(1'b1, 4'b0011, 1'b0, 4'hF);
    step(1'b1, 4'b0001, 1'b1, 4'h0);
    step(1'b1, 4'b0001, 1'b0, 4'h0);
    step(1'b1, 4'b0000, 1'b1, 4'h0);
    // R8: refused start at full depth, path end also present
    step(1'b1, 4'b1111, 1'b1, 4'h0);
    step(1'b1, 4'b0000, 1'b0, 4'h0);
    for (int k = 0; k < 12 && m_sp != 0; k++)
      step(1'b0, '0, 1'b1, 4'h0);
    step(1'b0, '0, 1'b0, 4'hA);

    // R8 flag persists while normal branching continues
    step(1'b1, 4'b1000, 1'b0, 4'hA);
    step(1'b1, 4'b1010, 1'b0, 4'h0);
    for (int k = 0; k < 8 && m_sp != 0; k++)
      step(1'b0, '0, 1'b1, 4'h3);
    step(1'b0, '0, 1'b0, 4'h3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule